// File: doc/BRIEF.md
# UART FIFO Trigger-Level Controller

This block owns the transmit and receive character queues of one serial channel, together with the control register that configures them. A small register write port programs a queue-enable bit, two one-shot queue flush commands, a legacy transfer-mode bit, two 2-bit level selects, a 2-bit table select and two directly programmable thresholds. From these settings the block derives a receive threshold and a transmit threshold.

It compares the live fill counts against those thresholds and drives two interrupt lines. The receive line reports that enough characters are waiting to be read. The transmit line reports that the queue needs refilling. A small state machine drives the transmit line and remembers whether the last reload carried the queue past its threshold. If it did not, the line waits for the queue to run empty.

The surrounding channel logic pushes received characters and pops characters to send, through strobes with data. Serial shifting, baud timing and bus access are outside this block.

Top module: `fifo_trig_ctrl`

Register addresses on `cfg_addr`: 0 = control register, 1 = table select (`cfg_wdata[1:0]`), 2 = programmable receive threshold, 3 = programmable transmit threshold. Control register layout: bit 0 = queue enable, bit 1 = receive flush, bit 2 = transmit flush, bit 3 = transfer-mode bit, bits [5:4] = transmit level select, bits [7:6] = receive level select.

Transmit interrupt states: `TX_EMPTY` (count zero, line high), `TX_UNDER` (filled but never past threshold, line low), `TX_OVER` (filled past threshold, line low), `TX_DRAINED` (dropped below threshold after being over it, line high). Transitions, one cycle behind the count: any state moves to `TX_EMPTY` when the count is zero. `TX_EMPTY` moves to `TX_OVER` when count > threshold, and to `TX_UNDER` otherwise. `TX_UNDER` moves to `TX_OVER` when count > threshold. `TX_OVER` moves to `TX_DRAINED` when count < threshold. `TX_DRAINED` moves back to `TX_OVER` when count > threshold.

## Requirements
- R1: After reset `ctrl_rd` is 0, both counts are 0, both overflow flags are 0, `rx_int` is 0 and `tx_int` is 1.
- R2: A control write with bit 0 clear sets the enable to 0 and leaves bits [7:3] unchanged. It flushes neither queue.
- R3: A control write with bits 0 and 1 set empties the receive queue at that edge. Bits 0 and 2 do the same for the transmit queue. Flush bits always read back as 0. A flush does not touch the other queue, and it wins over a push in the same cycle.
- R4: Control bit 3 is stored and read back on `ctrl_rd[3]`. It changes neither counts nor interrupts.
- R5: Table 0 gives receive thresholds 1, 4, 8, 14 for receive select codes 0 to 3, and a fixed transmit threshold of 1.
- R6: Table 1 gives receive thresholds 8, 16, 24, 28 and transmit thresholds 16, 8, 24, 30 for codes 0 to 3.
- R7: Table 2 gives receive thresholds 8, 16, 56, 60 and transmit thresholds 8, 16, 32, 56 for codes 0 to 3.
- R8: Table 3 uses the values written at addresses 2 and 3 as the thresholds, and ignores both level selects.
- R9: `rx_int` is high exactly while `rx_count` is at or above the receive threshold.
- R10: Once the transmit count has exceeded its threshold, `tx_int` rises one cycle after the count falls below the threshold.
- R11: If the transmit count has not exceeded the threshold since the queue was last empty, `tx_int` stays low until the count reaches 0. It is then high one cycle later.
- R12: Each queue holds 64 characters in arrival order. A push to a full queue with no pop is dropped and sets a sticky overflow flag, which only a flush or reset clears.
- R13: A pop from an empty queue leaves the count at 0 and the output data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register readback |
| rx_push | input | 1 | Push a received character |
| rx_din | input | 8 | Received character |
| rx_pop | input | 1 | Pop a character for the reader |
| rx_dout | output | 8 | Last character popped from the receive queue |
| rx_count | output | 7 | Receive fill level |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_push | input | 1 | Push a character to send |
| tx_din | input | 8 | Character to send |
| tx_pop | input | 1 | Pop a character for the transmitter |
| tx_dout | output | 8 | Last character popped from the transmit queue |
| tx_count | output | 7 | Transmit fill level |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_int | output | 1 | Receive threshold interrupt |
| tx_int | output | 1 | Transmit refill interrupt |

## Verification
A flush write and a push into the same queue can land on one clock edge, and so can a push and a pop on a full queue. The bench provokes the first by raising `rx_push` during the control write that flushes the receive queue. It passes when the count reads 0 afterwards and the transmit count is untouched. It provokes the second by pushing and popping together at 64 entries. It passes when the count stays at 64, no overflow is flagged, and the drained order includes the new character last.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
    localparam int unsigned Q_DEPTH = 64;
    localparam int unsigned Q_WIDTH = 8;

    typedef enum logic [1:0] {
        TX_EMPTY   = 2'd0,
        TX_UNDER   = 2'd1,
        TX_OVER    = 2'd2,
        TX_DRAINED = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_TABLE  = 2'd1,
        REG_PRG_RX = 2'd2,
        REG_PRG_TX = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/char_queue.sv
module char_queue #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             ovf
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             take_pop, take_push, full;

    assign full      = (count == CW'(DEPTH));
    assign take_pop  = pop && (count != '0) && !flush;
    assign take_push = push && !flush && (!full || take_pop);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (take_push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            dout   <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (take_push) wr_ptr <= bump(wr_ptr);
            if (take_pop) begin
                rd_ptr <= bump(rd_ptr);
                dout   <= store[rd_ptr];
            end
            count <= count + CW'(take_push) - CW'(take_pop);
            if (push && !take_push) ovf <= 1'b1;
        end
    end

    // R12
    count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R12
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && ovf));

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);

    // R13
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0 && $stable(dout)));
endmodule

// File: rtl/trig_decode.sv
module trig_decode #(
    parameter int unsigned CW = 7
) (
    input  logic [1:0]    tbl_sel,
    input  logic [1:0]    rx_code,
    input  logic [1:0]    tx_code,
    input  logic [CW-1:0] prg_rx,
    input  logic [CW-1:0] prg_tx,
    output logic [CW-1:0] rx_thr,
    output logic [CW-1:0] tx_thr
);
    always_comb begin
        rx_thr = CW'(1);
        tx_thr = CW'(1);
        unique case (tbl_sel)
            2'd0: begin
                unique case (rx_code)
                    2'd0: rx_thr = CW'(1);
                    2'd1: rx_thr = CW'(4);
                    2'd2: rx_thr = CW'(8);
                    2'd3: rx_thr = CW'(14);
                endcase
                tx_thr = CW'(1);
            end
            2'd1: begin
                unique case (rx_code)
                    2'd0: rx_thr = CW'(8);
                    2'd1: rx_thr = CW'(16);
                    2'd2: rx_thr = CW'(24);
                    2'd3: rx_thr = CW'(28);
                endcase
                unique case (tx_code)
                    2'd0: tx_thr = CW'(16);
                    2'd1: tx_thr = CW'(8);
                    2'd2: tx_thr = CW'(24);
                    2'd3: tx_thr = CW'(30);
                endcase
            end
            2'd2: begin
                unique case (rx_code)
                    2'd0: rx_thr = CW'(8);
                    2'd1: rx_thr = CW'(16);
                    2'd2: rx_thr = CW'(56);
                    2'd3: rx_thr = CW'(60);
                endcase
                unique case (tx_code)
                    2'd0: tx_thr = CW'(8);
                    2'd1: tx_thr = CW'(16);
                    2'd2: tx_thr = CW'(32);
                    2'd3: tx_thr = CW'(56);
                endcase
            end
            2'd3: begin
                rx_thr = prg_rx;
                tx_thr = prg_tx;
            end
        endcase
    end
endmodule

// File: rtl/tx_irq_fsm.sv
module tx_irq_fsm
    import fifo_trig_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] thr_i,
    output logic          irq_o
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (count_i == '0) begin
            state_d = TX_EMPTY;
        end else begin
            unique case (state_q)
                TX_EMPTY:   state_d = (count_i > thr_i) ? TX_OVER : TX_UNDER;
                TX_UNDER:   if (count_i > thr_i) state_d = TX_OVER;
                TX_OVER:    if (count_i < thr_i) state_d = TX_DRAINED;
                TX_DRAINED: if (count_i > thr_i) state_d = TX_OVER;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            TX_EMPTY, TX_DRAINED: irq_o = 1'b1;
            TX_UNDER, TX_OVER:    irq_o = 1'b0;
        endcase
    end

    // R11
    empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0) |=> irq_o);

    // R10
    below_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_OVER && count_i != '0 && count_i < thr_i) |=> irq_o);

    // R11
    under_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_UNDER && count_i != '0 && count_i <= thr_i) |=> !irq_o);
endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
    import fifo_trig_pkg::*;
#(
    parameter int unsigned WIDTH = Q_WIDTH,
    parameter int unsigned DEPTH = Q_DEPTH,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       ctrl_rd,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_din,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_dout,
    output logic [CW-1:0]    rx_count,
    output logic             rx_ovf,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_din,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_dout,
    output logic [CW-1:0]    tx_count,
    output logic             tx_ovf,
    output logic             rx_int,
    output logic             tx_int
);
    logic          q_on, xfer_mode;
    logic [1:0]    rx_code, tx_code, tbl_sel;
    logic [CW-1:0] prg_rx, prg_tx, rx_thr, tx_thr;
    logic          ctrl_wr, ctrl_ok, rx_flush, tx_flush;

    assign ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
    assign ctrl_ok  = ctrl_wr && cfg_wdata[0];
    assign rx_flush = ctrl_ok && cfg_wdata[1];
    assign tx_flush = ctrl_ok && cfg_wdata[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_on      <= 1'b0;
            xfer_mode <= 1'b0;
            rx_code   <= '0;
            tx_code   <= '0;
            tbl_sel   <= '0;
            prg_rx    <= CW'(1);
            prg_tx    <= CW'(1);
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_CTRL: begin
                    q_on <= cfg_wdata[0];
                    if (cfg_wdata[0]) begin
                        xfer_mode <= cfg_wdata[3];
                        tx_code   <= cfg_wdata[5:4];
                        rx_code   <= cfg_wdata[7:6];
                    end
                end
                REG_TABLE:  tbl_sel <= cfg_wdata[1:0];
                REG_PRG_RX: prg_rx  <= CW'(cfg_wdata);
                REG_PRG_TX: prg_tx  <= CW'(cfg_wdata);
            endcase
        end
    end

    assign ctrl_rd = {rx_code, tx_code, xfer_mode, 2'b00, q_on};

    char_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count), .ovf(rx_ovf)
    );

    char_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count), .ovf(tx_ovf)
    );

    trig_decode #(.CW(CW)) u_dec (
        .tbl_sel(tbl_sel), .rx_code(rx_code), .tx_code(tx_code),
        .prg_rx(prg_rx), .prg_tx(prg_tx), .rx_thr(rx_thr), .tx_thr(tx_thr)
    );

    tx_irq_fsm #(.CW(CW)) u_txfsm (
        .clk(clk), .rst_n(rst_n), .count_i(tx_count), .thr_i(tx_thr), .irq_o(tx_int)
    );

    assign rx_int = (rx_count >= rx_thr);

    // R2
    ctrl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !cfg_wdata[0]) |=> (ctrl_rd[0] == 1'b0 && ctrl_rd[7:3] == $past(ctrl_rd[7:3])));

    // R3
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_count == '0 && ctrl_rd[2:1] == 2'b00));

    // R3
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_count == '0));

    // R9
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && rx_thr != '0) |-> !rx_int);
endmodule

// File: tb/fifo_trig_ctrl_test.sv
module fifo_trig_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] ctrl_rd;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_din = '0, tx_din = '0, rx_dout, tx_dout;
    logic [6:0] rx_count, tx_count;
    logic       rx_ovf, tx_ovf, rx_int, tx_int;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_count(rx_count), .rx_ovf(rx_ovf),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .tx_count(tx_count), .tx_ovf(tx_ovf), .rx_int(rx_int), .tx_int(tx_int)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_din = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_din = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    function automatic int exp_rx(input int t, input int c);
        case (t)
            0: return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            1: return 8 + 8 * c - ((c == 3) ? 4 : 0);
            2: return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
            default: return 11;
        endcase
    endfunction

    function automatic int exp_tx(input int t, input int c);
        case (t)
            0: return 1;
            1: return (c == 0) ? 16 : (c == 1) ? 8 : (c == 2) ? 24 : 30;
            2: return (c == 3) ? 56 : 8 << c;
            default: return 6;
        endcase
    endfunction

    function automatic string tag_of(input int t);
        case (t)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check("R1 ctrl_rd", int'(ctrl_rd), 0);
        check("R1 rx_count", int'(rx_count), 0);
        check("R1 tx_count", int'(tx_count), 0);
        check("R1 ovf", int'({rx_ovf, tx_ovf}), 0);
        check("R1 rx_int", int'(rx_int), 0);
        check("R1 tx_int", int'(tx_int), 1);

        wr(2'd2, 8'd11);
        wr(2'd3, 8'd6);

        // R9 receive sweep over all tables and codes
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c < 4; c++) begin
                wr(2'd1, 8'(t));
                wr(2'd0, 8'((c << 6) | 8'h07));
                for (int n = 1; n <= 62; n++) begin
                    push_rx(8'(n));
                    check($sformatf("%s R9 rx_int t%0d c%0d n%0d", tag_of(t), t, c, n),
                          int'(rx_int), (n >= exp_rx(t, c)) ? 1 : 0);
                end
            end
        end

        // R10 transmit sweep
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c < 4; c++) begin
                int thr;
                thr = exp_tx(t, c);
                wr(2'd1, 8'(t));
                wr(2'd0, 8'((c << 4) | 8'h07));
                for (int n = 0; n <= thr; n++) push_tx(8'(n));
                idle();
                check($sformatf("%s R10 tx_int full t%0d c%0d", tag_of(t), t, c), int'(tx_int), 0);
                for (int k = thr; k >= 0; k--) begin
                    pop_tx();
                    idle();
                    check($sformatf("%s R10 tx_int t%0d c%0d k%0d", tag_of(t), t, c, k),
                          int'(tx_int), (k < thr) ? 1 : 0);
                end
            end
        end

        // R11 fallback: threshold 16, filled only to 5
        wr(2'd1, 8'd1);
        wr(2'd0, 8'h07);
        for (int n = 0; n < 5; n++) push_tx(8'(n));
        idle();
        check("R11 tx_int after partial fill", int'(tx_int), 0);
        for (int n = 0; n < 4; n++) pop_tx();
        idle();
        check("R11 tx_int at count 1", int'(tx_int), 0);
        pop_tx();
        idle();
        check("R11 tx_int at empty", int'(tx_int), 1);

        // R2 gated write: table 0, rx code 1 (threshold 4), 3 chars held
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h47);
        push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
        push_tx(8'h55);
        wr(2'd0, 8'hFE);
        check("R2 ctrl_rd", int'(ctrl_rd), 8'h40);
        check("R2 rx_count kept", int'(rx_count), 3);
        check("R2 tx_count kept", int'(tx_count), 1);
        check("R2 rx_int", int'(rx_int), 0);

        // R4 transfer-mode bit
        wr(2'd0, 8'h49);
        check("R4 ctrl_rd[3]", int'(ctrl_rd[3]), 1);
        check("R4 rx_count", int'(rx_count), 3);
        check("R4 rx_int", int'(rx_int), 0);
        push_rx(8'hA4);
        check("R4 rx_int at 4", int'(rx_int), 1);

        // R3 flush collides with push; other queue untouched
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h43;
        rx_push = 1'b1; rx_din = 8'hEE;
        @(negedge clk);
        cfg_we = 1'b0; rx_push = 1'b0;
        check("R3 rx_count after flush+push", int'(rx_count), 0);
        check("R3 tx_count untouched", int'(tx_count), 1);
        check("R3 flush bits read 0", int'(ctrl_rd), 8'h41);
        wr(2'd0, 8'h45);
        check("R3 tx flush", int'(tx_count), 0);

        // R13 empty pop
        pop_rx();
        check("R13 count", int'(rx_count), 0);
        check("R13 dout", int'(rx_dout), 0);

        // R12 fill, overflow, order
        for (int n = 0; n < 64; n++) push_rx(8'(n * 3 + 1));
        check("R12 full count", int'(rx_count), 64);
        check("R12 no ovf yet", int'(rx_ovf), 0);
        rx_push = 1'b1; rx_pop = 1'b1; rx_din = 8'hC3;
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0;
        check("R12 push+pop at full count", int'(rx_count), 64);
        check("R12 push+pop no ovf", int'(rx_ovf), 0);
        check("R12 first out", int'(rx_dout), 1);
        push_rx(8'hFF);
        check("R12 drop count", int'(rx_count), 64);
        check("R12 ovf set", int'(rx_ovf), 1);
        for (int n = 1; n < 64; n++) begin
            pop_rx();
            check($sformatf("R12 order %0d", n), int'(rx_dout), (n * 3 + 1) & 8'hFF);
        end
        pop_rx();
        check("R12 last is pushed-at-full", int'(rx_dout), 8'hC3);
        check("R12 ovf sticky", int'(rx_ovf), 1);
        pop_rx();
        check("R13 dout held", int'(rx_dout), 8'hC3);
        wr(2'd0, 8'h43);
        check("R12 flush clears ovf", int'(rx_ovf), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule